// File: doc/BRIEF.md
# Byte-Wide Asynchronous Memory Bus Master

This block lets on-chip control logic reach an external asynchronous static-memory device over an 8-bit address bus and an 8-bit data bus. It has three active-low bus strobes: chip enable, read and write. A single-cycle request pulse starts a one-byte write or read. The bus sequence then runs on a slow timing tick. That tick comes from one of four source enables, chosen by a 2-bit source select, and is divided by 1, 2, 4 or 8 under a 2-bit divide select. Busy flags show when a cycle is in flight. A read leaves its byte in a holding register and raises a valid flag.

The data pin is split into output, output-enable and input vectors, and the pad cell outside the block combines them. A mode bit turns the bus into plain general-purpose pins. The address pins then show a software-written output register, and the data pins are synchronised into an input register. Separate bits provide module enable, software reset and a pull-up request for the pads.

The sequencer is a six-state machine with these states:
- `ST_IDLE`: no bus activity.
- `ST_WR_SETUP`: chip enable and address.
- `ST_WR_STROBE`: data driven, write strobe low.
- `ST_WR_HOLD`: strobe released, address and data held.
- `ST_RD_OPEN`: chip enable and read strobe low.
- `ST_RD_LATCH`: read strobe still low, waiting for the capture tick.

The transitions are:
- IDLE→WR_SETUP on an accepted write request.
- IDLE→RD_OPEN on an accepted read request.
- WR_SETUP→WR_STROBE, WR_STROBE→WR_HOLD and WR_HOLD→IDLE, each on a bus tick.
- RD_OPEN→RD_LATCH on a bus tick.
- RD_LATCH→IDLE on the bus tick that captures the data.
- Any state→IDLE when the bus is not running. The bus is not running when the block is disabled, in general-purpose mode or in software reset.

Top module: `sram_bus_master`

## Requirements
- R1: After reset the block holds the following values: `pad_addr` is 0; `pad_ce_n`, `pad_rd_n` and `pad_wr_n` are 1; `pad_data_oe` is 0; both busy flags are 0; `rd_valid` is 0; `rd_data` is 0; `pad_pullup_en` is 0; `gpio_in` is 0.
- R2: An accepted write lowers `pad_ce_n` and drives `pad_addr` on the next clock edge. On the following bus tick, `pad_wr_n` goes low for exactly one bus period. After it rises, address and data stay driven with chip enable low for exactly one more bus period.
- R3: An accepted read lowers `pad_ce_n` and `pad_rd_n` together with the address. On the second bus tick after acceptance, `pad_data_in` is stored in `rd_data`, `rd_valid` is set and both strobes rise. The read strobe is therefore low for between P+1 and 2P clock cycles, where P is the bus period in cycles. `rd_valid` clears when the next read is accepted.
- R4: `pad_data_oe` is 1, with `pad_data_out` equal to the write byte, only from the start of the write strobe to the end of the hold period. It is 0 during setup, during reads and at all other times.
- R5: `wr_busy` is 1 from the edge that accepts a write until chip enable is released, and `rd_busy` does the same for reads. The two are never 1 together.
- R6: The block ignores `req_wr` and `req_rd` while a cycle is in flight. If both are raised in the same idle cycle, the write is taken.
- R7: The bus period is `1 << cfg_div_sel` pulses of `tick_src[cfg_src_sel]`.
- R8: With `cfg_gpio_mode` set, `pad_addr` shows the output register, which is loaded by `gpio_out_we` with `gpio_out_val`. The strobes stay high and requests are ignored.
- R9: In general-purpose mode, `gpio_in` equals `pad_data_in` after two clock edges. Outside that mode it reads 0.
- R10: `pad_pullup_en` follows `cfg_pullup` while `cfg_enable` is 1 and `cfg_soft_rst` is 0. Otherwise it is 0.
- R11: Setting `cfg_soft_rst` abandons any cycle, returns the pins to the R1 state and clears `rd_data`, `rd_valid` and the output register.
- R12: Clearing `cfg_enable` abandons any cycle and returns the pins to the R1 state, but keeps `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Module enable |
| cfg_soft_rst | input | 1 | Software reset |
| cfg_gpio_mode | input | 1 | General-purpose pin mode |
| cfg_pullup | input | 1 | Pull-up request |
| cfg_src_sel | input | 2 | Timing source select |
| cfg_div_sel | input | 2 | Divide select, ratio 1 << value |
| tick_src | input | 4 | Candidate timing enables |
| req_wr | input | 1 | Start a write (one-cycle pulse) |
| req_rd | input | 1 | Start a read (one-cycle pulse) |
| req_addr | input | 8 | Transfer address |
| req_wdata | input | 8 | Write byte |
| gpio_out_we | input | 1 | Load the output register |
| gpio_out_val | input | 8 | Output register value |
| wr_busy | output | 1 | Write in flight |
| rd_busy | output | 1 | Read in flight |
| rd_data | output | 8 | Last captured byte |
| rd_valid | output | 1 | Captured byte is fresh |
| gpio_in | output | 8 | Synchronised data pins in pin mode |
| pad_addr | output | 8 | Address pins |
| pad_ce_n | output | 1 | Chip enable, active low |
| pad_rd_n | output | 1 | Read strobe, active low |
| pad_wr_n | output | 1 | Write strobe, active low |
| pad_data_out | output | 8 | Data pin output value |
| pad_data_oe | output | 1 | Data pin output enable |
| pad_data_in | input | 8 | Data pin input value |
| pad_pullup_en | output | 1 | Pull-up enable for the pads |

## Verification
The bench builds the block with its default widths: 8-bit address and data, four timing sources and a 2-bit divide select. This keeps the full grid of source and divider settings small. All sixteen combinations are swept, with source k pulsing every k+1 cycles, so bus periods from 1 to 32 cycles are covered. For each combination the expected strobe widths follow from the product of source spacing and ratio, and a behavioural memory inside the bench checks the written and read-back bytes.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_SETUP  = 3'd1,
        ST_WR_STROBE = 3'd2,
        ST_WR_HOLD   = 3'd3,
        ST_RD_OPEN   = 3'd4,
        ST_RD_LATCH  = 3'd5
    } bus_state_t;

endpackage

// File: rtl/sbm_tick_gen.sv
module sbm_tick_gen #(
    parameter int SRC_N     = 4,
    parameter int DIV_SEL_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic [SRC_N-1:0]         tick_src,
    input  logic [$clog2(SRC_N)-1:0] src_sel,
    input  logic [DIV_SEL_W-1:0]     div_sel,
    output logic                     bus_tick
);
    // widest count is (2^(2^DIV_SEL_W - 1)) - 1
    localparam int CNT_W = (1 << DIV_SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             src_pulse;

    assign src_pulse = tick_src[src_sel];
    assign limit     = CNT_W'((32'd1 << div_sel) - 32'd1);
    assign bus_tick  = run && src_pulse && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (src_pulse) begin
            if (cnt_q >= limit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sbm_bus_fsm.sv
module sbm_bus_fsm
    import sbm_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic          bus_tick,
    input  logic          req_wr,
    input  logic          req_rd,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_din,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] dout_o,
    output logic          oe_o,
    output logic          ce_n_o,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic          wr_busy_o,
    output logic          rd_busy_o,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_valid_o
);
    bus_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rd_data_q;
    logic          rd_valid_q;
    logic          take_wr, take_rd, capture;

    assign take_wr = run && (state_q == ST_IDLE) && req_wr;
    assign take_rd = run && (state_q == ST_IDLE) && req_rd && !req_wr;
    assign capture = run && (state_q == ST_RD_LATCH) && bus_tick;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take_wr)      state_d = ST_WR_SETUP;
                    else if (take_rd) state_d = ST_RD_OPEN;
                end
                ST_WR_SETUP:  if (bus_tick) state_d = ST_WR_STROBE;
                ST_WR_STROBE: if (bus_tick) state_d = ST_WR_HOLD;
                ST_WR_HOLD:   if (bus_tick) state_d = ST_IDLE;
                ST_RD_OPEN:   if (bus_tick) state_d = ST_RD_LATCH;
                ST_RD_LATCH:  if (bus_tick) state_d = ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // transfer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            wdata_q    <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else if (clr) begin
            addr_q     <= '0;
            wdata_q    <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            if (take_wr) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (take_rd) begin
                addr_q     <= req_addr;
                rd_valid_q <= 1'b0;
            end
            if (capture) begin
                rd_data_q  <= bus_din;
                rd_valid_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        addr_o    = addr_q;
        dout_o    = '0;
        oe_o      = 1'b0;
        ce_n_o    = 1'b0;
        rd_n_o    = 1'b1;
        wr_n_o    = 1'b1;
        wr_busy_o = 1'b0;
        rd_busy_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                addr_o = '0;
                ce_n_o = 1'b1;
            end
            ST_WR_SETUP: begin
                wr_busy_o = 1'b1;
            end
            ST_WR_STROBE: begin
                wr_busy_o = 1'b1;
                oe_o      = 1'b1;
                dout_o    = wdata_q;
                wr_n_o    = 1'b0;
            end
            ST_WR_HOLD: begin
                wr_busy_o = 1'b1;
                oe_o      = 1'b1;
                dout_o    = wdata_q;
            end
            ST_RD_OPEN, ST_RD_LATCH: begin
                rd_busy_o = 1'b1;
                rd_n_o    = 1'b0;
            end
            default: begin
                addr_o = '0;
                ce_n_o = 1'b1;
            end
        endcase
    end

    assign rd_data_o  = rd_data_q;
    assign rd_valid_o = rd_valid_q;

endmodule

// File: rtl/sbm_gpio.sv
module sbm_gpio #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          active,
    input  logic          out_we,
    input  logic [AW-1:0] out_val,
    input  logic [DW-1:0] pin_in,
    output logic [AW-1:0] out_reg,
    output logic [DW-1:0] in_reg
);
    localparam int SYNC_N = 2;

    logic [AW-1:0] out_q;
    logic [DW-1:0] sync_q [SYNC_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (clr) begin
            out_q <= '0;
        end else if (out_we) begin
            out_q <= out_val;
        end
    end

    generate
        for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[s] <= '0;
                end else if (!active) begin
                    sync_q[s] <= '0;
                end else if (s == 0) begin
                    sync_q[s] <= pin_in;
                end else begin
                    sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign out_reg = out_q;
    assign in_reg  = sync_q[SYNC_N-1];

endmodule

// File: rtl/sram_bus_master.sv
module sram_bus_master #(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int SRC_N     = 4,
    parameter int DIV_SEL_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_enable,
    input  logic                     cfg_soft_rst,
    input  logic                     cfg_gpio_mode,
    input  logic                     cfg_pullup,
    input  logic [$clog2(SRC_N)-1:0] cfg_src_sel,
    input  logic [DIV_SEL_W-1:0]     cfg_div_sel,
    input  logic [SRC_N-1:0]         tick_src,
    input  logic                     req_wr,
    input  logic                     req_rd,
    input  logic [AW-1:0]            req_addr,
    input  logic [DW-1:0]            req_wdata,
    input  logic                     gpio_out_we,
    input  logic [AW-1:0]            gpio_out_val,
    output logic                     wr_busy,
    output logic                     rd_busy,
    output logic [DW-1:0]            rd_data,
    output logic                     rd_valid,
    output logic [DW-1:0]            gpio_in,
    output logic [AW-1:0]            pad_addr,
    output logic                     pad_ce_n,
    output logic                     pad_rd_n,
    output logic                     pad_wr_n,
    output logic [DW-1:0]            pad_data_out,
    output logic                     pad_data_oe,
    input  logic [DW-1:0]            pad_data_in,
    output logic                     pad_pullup_en
);
    logic          live;
    logic          bus_run;
    logic          pin_mode;
    logic          bus_tick;
    logic [AW-1:0] fsm_addr;
    logic [AW-1:0] gp_out;

    assign live     = cfg_enable && !cfg_soft_rst;
    assign bus_run  = live && !cfg_gpio_mode;
    assign pin_mode = live && cfg_gpio_mode;

    sbm_tick_gen #(
        .SRC_N     (SRC_N),
        .DIV_SEL_W (DIV_SEL_W)
    ) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (bus_run),
        .tick_src (tick_src),
        .src_sel  (cfg_src_sel),
        .div_sel  (cfg_div_sel),
        .bus_tick (bus_tick)
    );

    sbm_bus_fsm #(
        .AW (AW),
        .DW (DW)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (bus_run),
        .clr        (cfg_soft_rst),
        .bus_tick   (bus_tick),
        .req_wr     (req_wr),
        .req_rd     (req_rd),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .bus_din    (pad_data_in),
        .addr_o     (fsm_addr),
        .dout_o     (pad_data_out),
        .oe_o       (pad_data_oe),
        .ce_n_o     (pad_ce_n),
        .rd_n_o     (pad_rd_n),
        .wr_n_o     (pad_wr_n),
        .wr_busy_o  (wr_busy),
        .rd_busy_o  (rd_busy),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid)
    );

    sbm_gpio #(
        .AW (AW),
        .DW (DW)
    ) gpio_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_soft_rst),
        .active  (pin_mode),
        .out_we  (gpio_out_we),
        .out_val (gpio_out_val),
        .pin_in  (pad_data_in),
        .out_reg (gp_out),
        .in_reg  (gpio_in)
    );

    assign pad_addr      = pin_mode ? gp_out : fsm_addr;
    assign pad_pullup_en = cfg_pullup && live;

endmodule

// File: rtl/sbm_checker.sv
module sbm_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_gpio_mode,
    input logic wr_busy,
    input logic rd_busy,
    input logic rd_valid,
    input logic pad_ce_n,
    input logic pad_rd_n,
    input logic pad_wr_n,
    input logic pad_data_oe,
    input logic [7:0] pad_addr
);
    // R5
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_busy && rd_busy));

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pad_wr_n && !pad_rd_n));

    // R2
    strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pad_wr_n || !pad_rd_n) |-> !pad_ce_n);

    // R4
    oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_data_oe |-> (wr_busy && !pad_ce_n && pad_rd_n));

    // R4
    oe_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_wr_n) |-> pad_data_oe);

    // R2
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pad_ce_n && $past(!pad_ce_n)) |-> $stable(pad_addr));

    // R3
    valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $fell(rd_busy));

    // R8
    pin_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_gpio_mode && $past(cfg_gpio_mode)) |-> (pad_ce_n && pad_rd_n && pad_wr_n));

endmodule

bind sram_bus_master sbm_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_gpio_mode (cfg_gpio_mode),
    .wr_busy       (wr_busy),
    .rd_busy       (rd_busy),
    .rd_valid      (rd_valid),
    .pad_ce_n      (pad_ce_n),
    .pad_rd_n      (pad_rd_n),
    .pad_wr_n      (pad_wr_n),
    .pad_data_oe   (pad_data_oe),
    .pad_addr      (pad_addr)
);

// File: tb/sram_bus_master_tb_top.sv
module sram_bus_master_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0, cfg_soft_rst = 1'b0, cfg_gpio_mode = 1'b0, cfg_pullup = 1'b0;
    logic [1:0] cfg_src_sel = 2'd0, cfg_div_sel = 2'd0;
    logic [3:0] tick_src = 4'hF;
    logic       req_wr = 1'b0, req_rd = 1'b0;
    logic [7:0] req_addr = 8'h0, req_wdata = 8'h0;
    logic       gpio_out_we = 1'b0;
    logic [7:0] gpio_out_val = 8'h0;
    logic       wr_busy, rd_busy, rd_valid;
    logic [7:0] rd_data, gpio_in, pad_addr, pad_data_out, pad_data_in;
    logic       pad_ce_n, pad_rd_n, pad_wr_n, pad_data_oe, pad_pullup_en;

    logic       drv_en = 1'b0;
    logic [7:0] drv_val = 8'h0;
    logic [7:0] mem [256];
    logic       prev_wr_n = 1'b1;
    int         ph = 0;
    int         errors = 0, checks = 0;

    always #10 clk = ~clk;

    sram_bus_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_soft_rst(cfg_soft_rst),
        .cfg_gpio_mode(cfg_gpio_mode), .cfg_pullup(cfg_pullup), .cfg_src_sel(cfg_src_sel),
        .cfg_div_sel(cfg_div_sel), .tick_src(tick_src), .req_wr(req_wr), .req_rd(req_rd),
        .req_addr(req_addr), .req_wdata(req_wdata), .gpio_out_we(gpio_out_we),
        .gpio_out_val(gpio_out_val), .wr_busy(wr_busy), .rd_busy(rd_busy), .rd_data(rd_data),
        .rd_valid(rd_valid), .gpio_in(gpio_in), .pad_addr(pad_addr), .pad_ce_n(pad_ce_n),
        .pad_rd_n(pad_rd_n), .pad_wr_n(pad_wr_n), .pad_data_out(pad_data_out),
        .pad_data_oe(pad_data_oe), .pad_data_in(pad_data_in), .pad_pullup_en(pad_pullup_en)
    );

    // behavioural memory: answers while chip enable and read strobe are low
    assign pad_data_in = drv_en ? drv_val : ((!pad_ce_n && !pad_rd_n) ? mem[pad_addr] : 8'h00);

    // timing sources: source k pulses every k+1 cycles; stores on write strobe rise
    always @(negedge clk) begin
        ph = (ph == 11) ? 0 : ph + 1;
        for (int k = 0; k < 4; k++) tick_src[k] = ((ph % (k + 1)) == 0);
        if (!prev_wr_n && pad_wr_n && !pad_ce_n) mem[pad_addr] = pad_data_out;
        prev_wr_n = pad_wr_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d,
                            output int wlow, output int hold, output int bad);
        int guard;
        wlow = 0; hold = 0; bad = 0; guard = 0;
        @(negedge clk); req_wr = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk); req_wr = 1'b0;
        if (!wr_busy) bad++;
        while (!pad_ce_n && guard < 500) begin
            if (pad_addr != a) bad++;
            if (!pad_wr_n) begin
                wlow++;
                if (!pad_data_oe || pad_data_out != d) bad++;
            end else if (wlow > 0) begin
                hold++;
                if (!pad_data_oe || pad_data_out != d) bad++;
            end else if (pad_data_oe) begin
                bad++;
            end
            guard++;
            @(negedge clk);
        end
        if (wr_busy || pad_data_oe) bad++;
    endtask

    task automatic do_read(input logic [7:0] a, output int rlow, output int bad);
        int guard;
        rlow = 0; bad = 0; guard = 0;
        @(negedge clk); req_rd = 1'b1; req_addr = a;
        @(negedge clk); req_rd = 1'b0;
        if (!rd_busy || rd_valid) bad++;
        while (!pad_ce_n && guard < 500) begin
            if (!pad_rd_n) rlow++;
            if (pad_data_oe || pad_addr != a) bad++;
            guard++;
            @(negedge clk);
        end
        if (rd_busy) bad++;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int wl, hd, bd, rl, p, keep;
        logic [7:0] a, d;
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) & 8'hFF);
        wait_cyc(3);
        // R1 reset state
        chk(pad_addr == 0 && pad_ce_n && pad_rd_n && pad_wr_n && !pad_data_oe,
            "R1 pins", {pad_addr, pad_ce_n, pad_rd_n, pad_wr_n, pad_data_oe}, 8'h0 << 4 | 4'hE);
        chk(!wr_busy && !rd_busy && !rd_valid && rd_data == 0 && !pad_pullup_en && gpio_in == 0,
            "R1 status", {wr_busy, rd_busy, rd_valid, rd_data}, 0);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(pad_ce_n && pad_addr == 0, "R1 after release", pad_ce_n, 1);
        cfg_enable = 1'b1;

        // R7 R2 R3 sweep over all sources and divide settings
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 4; v++) begin
                cfg_src_sel = 2'(s); cfg_div_sel = 2'(v);
                p = (1 << v) * (s + 1);
                wait_cyc(40);
                a = 8'((s * 4 + v) * 13 + 5);
                d = 8'(((s * 4 + v) * 37) ^ 8'h5A);
                do_write(a, d, wl, hd, bd);
                chk(wl == p, "R7 R2 write strobe width", wl, p);
                chk(hd == p, "R2 hold width", hd, p);
                chk(bd == 0, "R4 R5 write phases", bd, 0);
                do_read(a, rl, bd);
                chk(rl >= p + 1 && rl <= 2 * p, "R3 read strobe width", rl, p + 1);
                chk(bd == 0, "R3 R4 read phases", bd, 0);
                chk(rd_data == d && rd_valid, "R3 read data", rd_data, d);
            end
        end

        // R6 requests while busy are ignored
        cfg_src_sel = 2'd0; cfg_div_sel = 2'd2;
        wait_cyc(10);
        @(negedge clk); req_wr = 1'b1; req_addr = 8'h10; req_wdata = 8'h11;
        @(negedge clk); req_wr = 1'b1; req_addr = 8'h20; req_wdata = 8'h22;
        @(negedge clk); req_wr = 1'b0; req_rd = 1'b1; req_addr = 8'h30;
        @(negedge clk); req_rd = 1'b0;
        while (!pad_ce_n) @(negedge clk);
        wait_cyc(2);
        chk(!wr_busy && !rd_busy && pad_ce_n, "R6 no queued cycle", {wr_busy, rd_busy}, 0);
        chk(rd_valid, "R6 read ignored keeps valid", rd_valid, 1);
        do_read(8'h20, rl, bd);
        chk(rd_data == 8'((8'h20 * 7 + 3) & 8'hFF), "R6 second write ignored", rd_data, (8'h20 * 7 + 3) & 8'hFF);
        do_read(8'h10, rl, bd);
        chk(rd_data == 8'h11, "R6 first write landed", rd_data, 8'h11);

        // R6 simultaneous requests: write wins
        @(negedge clk); req_wr = 1'b1; req_rd = 1'b1; req_addr = 8'h40; req_wdata = 8'h44;
        @(negedge clk); req_wr = 1'b0; req_rd = 1'b0;
        chk(wr_busy && !rd_busy, "R6 write priority", {wr_busy, rd_busy}, 2);
        while (!pad_ce_n) @(negedge clk);
        chk(mem[8'h40] == 8'h44, "R6 priority write stored", mem[8'h40], 8'h44);

        // R10 pull-up
        cfg_pullup = 1'b1;
        @(negedge clk);
        chk(pad_pullup_en, "R10 pull-up on", pad_pullup_en, 1);

        // R8 pin mode
        cfg_gpio_mode = 1'b1;
        @(negedge clk); gpio_out_we = 1'b1; gpio_out_val = 8'hA5;
        @(negedge clk); gpio_out_we = 1'b0;
        chk(pad_addr == 8'hA5 && pad_ce_n, "R8 output register", pad_addr, 8'hA5);
        @(negedge clk); req_wr = 1'b1; req_addr = 8'h01;
        @(negedge clk); req_wr = 1'b0;
        chk(!wr_busy && pad_ce_n && pad_wr_n && pad_addr == 8'hA5, "R8 request ignored", wr_busy, 0);
        // R9 input sync
        drv_en = 1'b1; drv_val = 8'h3C;
        @(negedge clk);
        chk(gpio_in != 8'h3C, "R9 two-edge latency", gpio_in, 0);
        @(negedge clk);
        chk(gpio_in == 8'h3C, "R9 sampled pins", gpio_in, 8'h3C);
        drv_en = 1'b0;
        cfg_gpio_mode = 1'b0;
        wait_cyc(2);
        chk(gpio_in == 0 && pad_addr == 0, "R9 reads zero outside pin mode", gpio_in, 0);

        // R12 disable mid read keeps rd_data
        keep = rd_data;
        @(negedge clk); req_rd = 1'b1; req_addr = 8'h55;
        @(negedge clk); req_rd = 1'b0;
        cfg_enable = 1'b0;
        @(negedge clk);
        chk(pad_ce_n && pad_rd_n && !rd_busy && pad_addr == 0, "R12 disable idles pins", pad_ce_n, 1);
        chk(rd_data == 8'(keep), "R12 rd_data kept", rd_data, keep);
        chk(!pad_pullup_en, "R10 pull-up off when disabled", pad_pullup_en, 0);
        cfg_enable = 1'b1;
        wait_cyc(5);

        // R11 soft reset mid write
        @(negedge clk); req_wr = 1'b1; req_addr = 8'h66; req_wdata = 8'h77;
        @(negedge clk); req_wr = 1'b0;
        wait_cyc(5);
        cfg_soft_rst = 1'b1;
        @(negedge clk);
        chk(pad_ce_n && pad_wr_n && !pad_data_oe && !wr_busy && pad_addr == 0, "R11 pins reset", wr_busy, 0);
        chk(rd_data == 0 && !rd_valid, "R11 read register cleared", rd_data, 0);
        cfg_soft_rst = 1'b0;
        cfg_gpio_mode = 1'b1;
        @(negedge clk);
        chk(pad_addr == 0, "R11 output register cleared", pad_addr, 0);
        cfg_gpio_mode = 1'b0;
        wait_cyc(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule